// File: doc/BRIEF.md
# Descriptor-Ring Receive DMA Engine

This block moves received Ethernet frames from a byte stream into system memory through a ring of 32-byte descriptors. Each frame starts only while software has the receive-start bit set. The first 12 bytes of a frame are held inside the block. Frames shorter than that are discarded without any memory access. Once 12 bytes have arrived, the engine reads the current descriptor. If the descriptor is not owned by hardware, the rest of the frame is thrown away. Otherwise the bytes go to the descriptor's buffer, and a completion word that carries the length is written back.

The engine keeps its own current-descriptor pointer. After each completed frame the pointer steps to the next descriptor, or returns to the ring base when the descriptor carries a wrap flag. Every completed frame is classified by its destination address as unicast, multicast or broadcast and counted. Status bits are sticky and write-one-to-clear, and a single interrupt line reports any status bit that is enabled.

Top module: `rx_ring_dma`

## Requirements
- R1: While control register bit 1 (receive start) is clear and no frame is in progress, `s_ready` stays low and no frame byte is taken.
- R2: A frame that ends before its 12th byte causes no memory access, leaves the pointer and counters unchanged, and sets status bit 6 (receive done) and bit 16 (normal summary).
- R3: When word 0 bit 31 (ownership) of the fetched descriptor is clear, the frame is consumed and dropped with no memory write, the pointer is unchanged, and status bit 7 (buffer unavailable) and bit 15 (abnormal summary) are set.
- R4: Descriptor word 0 (control/status) is at offset 0, word 1 (bits 15:0 = buffer size field) is at offset 4, and word 2 (buffer address) is at offset 8. Frame byte i is written to byte address buffer+i, using a single byte lane selected by address bits 1:0.
- R5: On success, word 0 of the descriptor is overwritten with ((length + 4) << 16) | 0x300, which clears ownership.
- R6: After a completed frame the pointer reloads from the base register if bit 15 of word 1 is set, and otherwise advances by 32.
- R7: A destination of six 0xFF bytes counts as broadcast. A destination whose first byte has bit 0 set and that is not broadcast counts as multicast. The frame, byte (length + 4), broadcast and multicast counters update per completed frame.
- R8: A completed frame sets status bits 6 and 16. Writing ones to the status register clears those bits. `irq` is high exactly when some status bit and its enable bit are both set.
- R9: Writing the base register loads both the base and the current pointer. Register addresses are: 0 control, 1 interrupt enable, 2 status, 3 base, 4 current pointer, 5 frames, 6 bytes, 7 broadcast, 8 multicast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| irq | output | 1 | Interrupt: any enabled status bit |
| s_valid | input | 1 | Frame byte valid |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Final byte of frame |
| s_ready | output | 1 | Engine accepts the byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 32 | Byte address |
| mem_wstrb | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The hardest case to reach is a frame that is refused for ownership after its header has been buffered. In that case the engine must keep draining the stream without writing memory and must leave the pointer where it was. The bench reaches this case by placing a descriptor with ownership clear in its memory model at the exact slot the pointer is expected to hold. The vector table also covers a frame of exactly 12 bytes, where the last byte arrives before the descriptor fetch, and a frame that is one byte short of the header. It also runs a wrap followed by a step, so that the pointer returns through the base.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
    typedef enum logic [2:0] {
        ST_HDR, ST_FETCH, ST_COPY, ST_STREAM, ST_DRAIN, ST_WB
    } rx_state_e;

    localparam int BIT_RDONE = 6;
    localparam int BIT_RUNAV = 7;
    localparam int BIT_ABN   = 15;
    localparam int BIT_NRM   = 16;

    localparam logic [3:0] RA_CTRL = 4'd0;
    localparam logic [3:0] RA_IE   = 4'd1;
    localparam logic [3:0] RA_STAT = 4'd2;
    localparam logic [3:0] RA_BASE = 4'd3;
    localparam logic [3:0] RA_CUR  = 4'd4;
    localparam logic [3:0] RA_FRM  = 4'd5;
    localparam logic [3:0] RA_BYT  = 4'd6;
    localparam logic [3:0] RA_BC   = 4'd7;
    localparam logic [3:0] RA_MC   = 4'd8;
endpackage

// File: rtl/rx_ring_classify.sv
module rx_ring_classify (
    input  logic [47:0] dest,
    output logic        is_bcast,
    output logic        is_mcast
);
    always_comb begin
        is_bcast = &dest;
        is_mcast = dest[0] && !is_bcast;
    end
endmodule

// File: rtl/rx_ring_regs.sv
module rx_ring_regs
    import rx_ring_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 14,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic             irq,
    input  logic             ev_short,
    input  logic             ev_unavail,
    input  logic             ev_done,
    input  logic             ev_wrap,
    input  logic [LEN_W-1:0] ev_len,
    input  logic             is_bcast,
    input  logic             is_mcast,
    output logic             rx_en,
    output logic [AW-1:0]    cur_ptr
);
    localparam logic [AW-1:0] DESC_BYTES = AW'(32);
    localparam logic [CNT_W-1:0] CRC_BYTES = CNT_W'(4);

    typedef struct packed {
        logic             rx_on;
        logic [31:0]      ie;
        logic [31:0]      stat;
        logic [AW-1:0]    base;
        logic [AW-1:0]    cur;
        logic [CNT_W-1:0] frames;
        logic [CNT_W-1:0] bytes;
        logic [CNT_W-1:0] bc;
        logic [CNT_W-1:0] mc;
    } regs_t;

    regs_t q, n;
    logic [31:0] clr, set;
    logic        base_wr;

    always_comb begin
        n       = q;
        clr     = '0;
        set     = '0;
        base_wr = cfg_we && (cfg_addr == RA_BASE);
        if (cfg_we) begin
            case (cfg_addr)
                RA_CTRL: n.rx_on = cfg_wdata[1];
                RA_IE:   n.ie    = cfg_wdata;
                RA_STAT: clr     = cfg_wdata;
                RA_BASE: begin
                    n.base = cfg_wdata[AW-1:0];
                    n.cur  = cfg_wdata[AW-1:0];
                end
                default: ;
            endcase
        end
        if (ev_short || ev_done) begin
            set[BIT_RDONE] = 1'b1;
            set[BIT_NRM]   = 1'b1;
        end
        if (ev_unavail) begin
            set[BIT_RUNAV] = 1'b1;
            set[BIT_ABN]   = 1'b1;
        end
        if (ev_done) begin
            n.frames = q.frames + 1'b1;
            n.bytes  = q.bytes + CNT_W'(ev_len) + CRC_BYTES;
            if (is_bcast) n.bc = q.bc + 1'b1;
            if (is_mcast) n.mc = q.mc + 1'b1;
            if (!base_wr) n.cur = ev_wrap ? q.base : q.cur + DESC_BYTES;
        end
        n.stat = (q.stat & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        case (cfg_addr)
            RA_CTRL: cfg_rdata = {30'd0, q.rx_on, 1'b0};
            RA_IE:   cfg_rdata = q.ie;
            RA_STAT: cfg_rdata = q.stat;
            RA_BASE: cfg_rdata = 32'(q.base);
            RA_CUR:  cfg_rdata = 32'(q.cur);
            RA_FRM:  cfg_rdata = 32'(q.frames);
            RA_BYT:  cfg_rdata = 32'(q.bytes);
            RA_BC:   cfg_rdata = 32'(q.bc);
            RA_MC:   cfg_rdata = 32'(q.mc);
            default: cfg_rdata = '0;
        endcase
    end

    assign irq     = |(q.stat & q.ie);
    assign rx_en   = q.rx_on;
    assign cur_ptr = q.cur;

    // R9: a base write takes over the pointer on the next cycle
    a_r9_base_load: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> (q.cur == $past(cfg_wdata[AW-1:0])));
    // R6: step without wrap
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_done && !ev_wrap && !base_wr) |=> (q.cur == $past(q.cur) + DESC_BYTES));
    // R6: wrap returns to base
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_done && ev_wrap && !base_wr) |=> (q.cur == $past(q.base)));
    // R8: cleared bits stay cleared when no event sets them
    a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == RA_STAT && !ev_done && !ev_short && !ev_unavail)
        |=> ((q.stat & $past(cfg_wdata)) == 32'd0));
    // R7: byte counter adds length plus the CRC bytes
    a_r7_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> (q.bytes == $past(q.bytes) + CNT_W'($past(ev_len)) + CRC_BYTES));
endmodule

// File: rtl/rx_ring_fsm.sv
module rx_ring_fsm
    import rx_ring_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 14,
    parameter int HDR_N = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic [AW-1:0]    cur_ptr,
    input  logic             s_valid,
    input  logic [7:0]       s_data,
    input  logic             s_last,
    output logic             s_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [3:0]       mem_wstrb,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    output logic             ev_short,
    output logic             ev_unavail,
    output logic             ev_done,
    output logic             ev_wrap,
    output logic [LEN_W-1:0] ev_len,
    output logic [47:0]      dest
);
    localparam int IW = $clog2(HDR_N);
    localparam logic [LEN_W-1:0] HDR_LAST = LEN_W'(HDR_N - 1);
    localparam logic [IW-1:0]    IDX_LAST = IW'(HDR_N - 1);
    localparam logic [IW-1:0]    FETCH_END = IW'(3);

    typedef struct packed {
        rx_state_e          st;
        logic [LEN_W-1:0]   cnt;
        logic [IW-1:0]      idx;
        logic               own;
        logic               wrap;
        logic [AW-1:0]      buf_addr;
        logic               got_last;
        logic [HDR_N*8-1:0] hdr;
    } fsm_t;

    fsm_t q, n;
    logic [AW-1:0] byte_addr;

    always_comb begin
        n          = q;
        s_ready    = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wstrb  = '0;
        mem_wdata  = '0;
        ev_short   = 1'b0;
        ev_unavail = 1'b0;
        ev_done    = 1'b0;
        ev_wrap    = 1'b0;
        ev_len     = q.cnt;
        byte_addr  = '0;
        case (q.st)
            ST_HDR: begin
                s_ready = rx_en || (q.cnt != '0);
                if (s_valid && s_ready) begin
                    n.hdr[q.cnt[IW-1:0]*8 +: 8] = s_data;
                    n.cnt = q.cnt + 1'b1;
                    if (q.cnt == HDR_LAST) begin
                        n.st       = ST_FETCH;
                        n.idx      = '0;
                        n.got_last = s_last;
                    end else if (s_last) begin
                        ev_short = 1'b1;
                        n.cnt    = '0;
                    end
                end
            end
            ST_FETCH: begin
                if (q.idx != FETCH_END) begin
                    mem_req  = 1'b1;
                    mem_addr = cur_ptr + AW'({q.idx, 2'b00});
                    n.idx    = q.idx + 1'b1;
                end
                case (q.idx)
                    IW'(1): n.own  = mem_rdata[31];
                    IW'(2): n.wrap = mem_rdata[15];
                    default: ;
                endcase
                if (q.idx == FETCH_END) begin
                    n.buf_addr = mem_rdata[AW-1:0];
                    n.idx      = '0;
                    if (q.own) begin
                        n.st = ST_COPY;
                    end else begin
                        ev_unavail = 1'b1;
                        n.cnt      = '0;
                        n.st       = q.got_last ? ST_HDR : ST_DRAIN;
                    end
                end
            end
            ST_COPY: begin
                byte_addr = q.buf_addr + AW'(q.idx);
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = byte_addr;
                mem_wstrb = 4'b0001 << byte_addr[1:0];
                mem_wdata = {4{q.hdr[q.idx*8 +: 8]}};
                if (q.idx == IDX_LAST) n.st = q.got_last ? ST_WB : ST_STREAM;
                else                   n.idx = q.idx + 1'b1;
            end
            ST_STREAM: begin
                s_ready = 1'b1;
                if (s_valid) begin
                    byte_addr = q.buf_addr + AW'(q.cnt);
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = byte_addr;
                    mem_wstrb = 4'b0001 << byte_addr[1:0];
                    mem_wdata = {4{s_data}};
                    n.cnt     = q.cnt + 1'b1;
                    if (s_last) n.st = ST_WB;
                end
            end
            ST_DRAIN: begin
                s_ready = 1'b1;
                if (s_valid && s_last) n.st = ST_HDR;
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_ptr;
                mem_wstrb = 4'hf;
                mem_wdata = ((32'(q.cnt) + 32'd4) << 16) | 32'h0000_0300;
                ev_done   = 1'b1;
                ev_wrap   = q.wrap;
                n.cnt     = '0;
                n.st      = ST_HDR;
            end
            default: n.st = ST_HDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_HDR, default: '0};
        else        q <= n;
    end

    assign dest = q.hdr[47:0];

    // R1: nothing is taken while receive is off between frames
    a_r1_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HDR && q.cnt == '0 && !rx_en) |-> !s_ready);
    // R2: a short frame never reaches memory
    a_r2_short_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ev_short |-> !mem_req);
    // R3: a refused frame is drained without memory traffic
    a_r3_drain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DRAIN) |-> !mem_req);
    // R4: data writes touch exactly one byte lane
    a_r4_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_wstrb != 4'hf) |-> ($countones(mem_wstrb) == 1));
    // R5: completion word releases ownership and carries the fixed flags
    a_r5_wb_word: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_wstrb == 4'hf)
        |-> (!mem_wdata[31] && mem_wdata[15:0] == 16'h0300));
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
    import rx_ring_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 14,
    parameter int CNT_W = 32,
    parameter int HDR_N = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [3:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    output logic          irq,
    input  logic          s_valid,
    input  logic [7:0]    s_data,
    input  logic          s_last,
    output logic          s_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_wstrb,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata
);
    logic             rx_en, ev_short, ev_unavail, ev_done, ev_wrap;
    logic             is_bcast, is_mcast;
    logic [LEN_W-1:0] ev_len;
    logic [AW-1:0]    cur_ptr;
    logic [47:0]      dest;

    rx_ring_fsm #(.AW(AW), .LEN_W(LEN_W), .HDR_N(HDR_N)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cur_ptr(cur_ptr),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ev_short(ev_short), .ev_unavail(ev_unavail), .ev_done(ev_done),
        .ev_wrap(ev_wrap), .ev_len(ev_len), .dest(dest)
    );

    rx_ring_classify u_cls (
        .dest(dest), .is_bcast(is_bcast), .is_mcast(is_mcast)
    );

    rx_ring_regs #(.AW(AW), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
        .ev_short(ev_short), .ev_unavail(ev_unavail), .ev_done(ev_done),
        .ev_wrap(ev_wrap), .ev_len(ev_len), .is_bcast(is_bcast),
        .is_mcast(is_mcast), .rx_en(rx_en), .cur_ptr(cur_ptr)
    );
endmodule

// File: tb/sim_rx_ring_dma.sv
`timescale 1ns/1ps
module sim_rx_ring_dma;
    import rx_ring_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_last = 1'b0;
    logic        s_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_wstrb;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem [256];

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    rx_ring_dma u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_wstrb[b]) mem[mem_addr[9:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[9:2]];
            end
        end
    end

    // {length[13:0], kind[1:0] (0 uni,1 multi,2 broad), own, wrap}
    localparam int NV = 6;
    localparam logic [17:0] VEC [NV] = '{
        {14'd20, 2'd0, 1'b1, 1'b0},
        {14'd12, 2'd1, 1'b1, 1'b1},
        {14'd64, 2'd2, 1'b1, 1'b0},
        {14'd30, 2'd0, 1'b0, 1'b0},
        {14'd11, 2'd1, 1'b1, 1'b0},
        {14'd13, 2'd1, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    function automatic logic [7:0] fbyte(input int v, input int i, input int kind);
        if (i < 6) begin
            if (kind == 2) return 8'hff;
            if (i == 0)    return (kind == 1) ? 8'h01 : 8'h02;
            return 8'(8'h20 + i);
        end
        return 8'((i * 7 + v * 13) & 255);
    endfunction

    task automatic send(input int v, input int len, input int kind);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            s_valid = 1'b1; s_data = fbyte(v, i, kind); s_last = (i == len - 1);
            while (!s_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return mem[a[9:2]][a[1:0]*8 +: 8];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, ptr, bufa, exp_w0;
        int frames, bytes, bc, mc;
        frames = 0; bytes = 0; bc = 0; mc = 0; ptr = 0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(RA_STAT, r); chk("R8 reset status", r, 0);
        rd(RA_CUR, r);  chk("R9 reset pointer", r, 0);
        chk("R8 reset irq", 32'(irq), 0);
        // R1: receive off, offered byte is not taken
        s_valid = 1'b1; s_data = 8'h55;
        repeat (4) begin
            @(negedge clk);
            chk("R1 ready low while off", 32'(s_ready), 0);
        end
        s_valid = 1'b0;
        rd(RA_STAT, r); chk("R1 no status while off", r, 0);

        wr(RA_BASE, 32'h0);
        wr(RA_CTRL, 32'h2);
        @(negedge clk);
        chk("R1 ready high when on", 32'(s_ready), 1);

        for (int v = 0; v < NV; v++) begin
            int len, kind;
            logic own, wrp;
            len  = int'(VEC[v][17:4]);
            kind = int'(VEC[v][3:2]);
            own  = VEC[v][1];
            wrp  = VEC[v][0];
            bufa = 32'h200 + 32'(v * 64);
            mem[ptr[9:2]]     = {own, 31'd0};
            mem[ptr[9:2] + 1] = {16'd0, wrp, 15'd64};
            mem[ptr[9:2] + 2] = bufa;
            for (int k = 0; k < 16; k++) mem[bufa[9:2] + 8'(k)] = '0;
            wr(RA_STAT, 32'hffff_ffff);
            send(v, len, kind);
            repeat (30) @(negedge clk);
            if (len < 12) begin
                rd(RA_STAT, r); chk("R2 short status", r, 32'h0001_0040);
                chk("R2 descriptor untouched", mem[ptr[9:2]], {own, 31'd0});
                chk("R2 buffer untouched", mem[bufa[9:2]], 0);
            end else if (!own) begin
                rd(RA_STAT, r); chk("R3 unavailable status", r, 32'h0000_8080);
                chk("R3 descriptor untouched", mem[ptr[9:2]], 0);
                chk("R3 buffer untouched", mem[bufa[9:2]], 0);
            end else begin
                rd(RA_STAT, r); chk("R8 done status", r, 32'h0001_0040);
                exp_w0 = (32'(len + 4) << 16) | 32'h300;
                chk("R5 completion word", mem[ptr[9:2]], exp_w0);
                for (int i = 0; i < len; i++)
                    chk("R4 data byte", 32'(mbyte(bufa + 32'(i))), 32'(fbyte(v, i, kind)));
                frames++; bytes += len + 4;
                if (kind == 2) bc++;
                if (kind == 1) mc++;
                ptr = wrp ? 32'h0 : ptr + 32;
            end
            rd(RA_CUR, r); chk("R6 pointer", r, ptr);
            rd(RA_FRM, r); chk("R7 frame count", r, 32'(frames));
        end
        rd(RA_BYT, r); chk("R7 byte count", r, 32'(bytes));
        rd(RA_BC, r);  chk("R7 broadcast count", r, 32'(bc));
        rd(RA_MC, r);  chk("R7 multicast count", r, 32'(mc));

        // R8 interrupt and write-one-to-clear
        chk("R8 irq off with no enable", 32'(irq), 0);
        wr(RA_IE, 32'h40);
        chk("R8 irq on", 32'(irq), 1);
        wr(RA_STAT, 32'h40);
        rd(RA_STAT, r); chk("R8 partial clear", r, 32'h0001_0000);
        chk("R8 irq off after clear", 32'(irq), 0);

        // R9 base write moves the pointer
        wr(RA_BASE, 32'h100);
        rd(RA_CUR, r); chk("R9 pointer loaded", r, 32'h100);
        rd(RA_BASE, r); chk("R9 base loaded", r, 32'h100);

        // R1 disable again: ready drops between frames
        wr(RA_CTRL, 32'h0);
        @(negedge clk);
        chk("R1 ready low after disable", 32'(s_ready), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule